// File: doc/BRIEF.md
# Single-Channel DMA Transfer Engine

This block moves a run of words between one peripheral and memory without the processor touching each word. Software sets up a start address, a word count, a transfer mode and an enable bit through a small register port. The port is addressed by four bits and qualified by a chip select. When the peripheral raises its request, the channel asks for the system bus with a hold request. Once the bus is granted, the channel drives a memory address, one memory strobe and an acknowledge to the peripheral. The peripheral and memory then exchange the word directly on the data bus, so the channel carries no data itself.

Three pacing modes are supported. Single mode gives the bus back after every word. Block mode keeps the bus until the count is used up. Demand mode keeps the bus only while the peripheral keeps asking. An auto-reload option restarts the channel from its programmed address and count each time a run finishes, which suits circular buffers. The end of a run sets a terminal-count flag. That flag drives an interrupt line and is cleared by reading the status register.

Top module: `dmac_channel`

## Requirements
- R1: Register offsets: 0 is the address, 1 is the word count, 2 is the mode, 3 is the command and 4 is the status. The mode register holds bits[1:0] kind (0 single, 1 block, 2 demand), bit2 direction and bit3 auto-reload. Command bit0 is enable, and status bit0 is the terminal-count flag. A write to offset 0 or 1 loads both a base copy and a working copy. Reads of offsets 0 and 1 return the working copy. Every register resets to zero.
- R2: Hold request rises only when the channel is enabled, the count is nonzero, the peripheral request is high and hold acknowledge is low. Acknowledge, address and strobes are driven only after hold acknowledge has been seen; otherwise the address reads zero.
- R3: Each completed word (strobe active with ready high) raises the address by one and lowers the count by one.
- R4: While ready is low, the current cycle is stretched: the address, strobe and acknowledge hold their values.
- R5: Direction 1 (peripheral to memory) asserts the memory write strobe; direction 0 (memory to peripheral) asserts the memory read strobe; never both.
- R6: In single mode exactly one word moves per bus grant, after which hold request falls.
- R7: In block mode the run continues to zero count under a single grant, even if the peripheral request falls after the acknowledge.
- R8: In demand mode, if the request is low when a word completes, the channel releases the bus. It keeps its address and count and resumes from there on the next request.
- R9: When the count reaches zero the bus is released, and the terminal-count flag and interrupt go high. A status read clears them.
- R10: With auto-reload set, reaching zero restores the base address and count, and the channel accepts new requests.
- R11: A disabled channel or a channel with zero count never raises hold request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Register port select |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register offset |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data |
| dreq | input | 1 | Peripheral transfer request |
| dack | output | 1 | Peripheral acknowledge, high during a bus cycle |
| hold_req | output | 1 | Request for the system bus |
| hold_ack | input | 1 | Bus granted |
| ready | input | 1 | Low to stretch the current cycle |
| mem_addr | output | 16 | Memory address during a bus cycle |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| irq | output | 1 | Terminal-count interrupt |

## Verification
The assertions assume that hold acknowledge stays high for as long as hold request does, once it has been granted. They also assume that software does not write the address or count registers while a run is in progress. The stimulus meets both conditions. The arbiter in the bench simply follows hold request one half-cycle later. All register programming happens while the channel is idle or waiting for a request. Ready and the peripheral request are changed only on falling edges, so every input is stable at the sampling edge.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

    localparam logic [3:0] OFS_ADDR = 4'd0;
    localparam logic [3:0] OFS_CNT  = 4'd1;
    localparam logic [3:0] OFS_MODE = 4'd2;
    localparam logic [3:0] OFS_CMD  = 4'd3;
    localparam logic [3:0] OFS_STAT = 4'd4;

    typedef enum logic [1:0] {
        XM_SINGLE = 2'd0,
        XM_BLOCK  = 2'd1,
        XM_DEMAND = 2'd2,
        XM_RSVD   = 2'd3
    } xfer_kind_e;

    typedef struct packed {
        logic       autoload;
        logic       to_mem;
        xfer_kind_e kind;
    } mode_cfg_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ASK  = 2'd1,
        ST_MOVE = 2'd2
    } seq_state_e;

    // After a word completes: stay on the bus for another word?
    function automatic logic keep_bus(xfer_kind_e k, logic req_now, logic last);
        keep_bus = !last && ((k == XM_BLOCK) || (k == XM_DEMAND && req_now));
    endfunction

endpackage

// File: rtl/dmac_regs.sv
module dmac_regs
    import dmac_pkg::*;
#(
    parameter int REG_W = 16,
    parameter int RA_W  = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cs,
    input  logic             wr,
    input  logic             rd,
    input  logic [RA_W-1:0]  addr,
    input  logic [REG_W-1:0] wdata,
    input  logic             word_done,
    output logic [REG_W-1:0] rdata,
    output logic [REG_W-1:0] cur_addr,
    output logic [REG_W-1:0] cur_cnt,
    output mode_cfg_t        cfg,
    output logic             enabled,
    output logic             last,
    output logic             cnt_zero,
    output logic             tc_flag
);
    localparam int CFG_W = $bits(mode_cfg_t);

    logic [REG_W-1:0] base_addr;
    logic [REG_W-1:0] base_cnt;
    logic             wr_any;
    logic             hit_addr, hit_cnt, hit_mode, hit_cmd, rd_stat;

    assign wr_any   = cs && wr;
    assign hit_addr = wr_any && (addr == RA_W'(OFS_ADDR));
    assign hit_cnt  = wr_any && (addr == RA_W'(OFS_CNT));
    assign hit_mode = wr_any && (addr == RA_W'(OFS_MODE));
    assign hit_cmd  = wr_any && (addr == RA_W'(OFS_CMD));
    assign rd_stat  = cs && rd && (addr == RA_W'(OFS_STAT));

    assign last     = (cur_cnt == REG_W'(1));
    assign cnt_zero = (cur_cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            base_addr <= '0;
            base_cnt  <= '0;
            cur_addr  <= '0;
            cur_cnt   <= '0;
            cfg       <= '0;
            enabled   <= 1'b0;
            tc_flag   <= 1'b0;
        end else begin
            if (hit_addr) begin
                base_addr <= wdata;
                cur_addr  <= wdata;
            end else if (word_done) begin
                cur_addr <= (last && cfg.autoload) ? base_addr : cur_addr + REG_W'(1);
            end

            if (hit_cnt) begin
                base_cnt <= wdata;
                cur_cnt  <= wdata;
            end else if (word_done) begin
                cur_cnt <= (last && cfg.autoload) ? base_cnt : cur_cnt - REG_W'(1);
            end

            if (hit_mode) cfg     <= mode_cfg_t'(wdata[CFG_W-1:0]);
            if (hit_cmd)  enabled <= wdata[0];

            // set wins over a coincident status read
            if (word_done && last) tc_flag <= 1'b1;
            else if (rd_stat)      tc_flag <= 1'b0;
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            RA_W'(OFS_ADDR): rdata = cur_addr;
            RA_W'(OFS_CNT):  rdata = cur_cnt;
            RA_W'(OFS_MODE): rdata = {{(REG_W-CFG_W){1'b0}}, cfg};
            RA_W'(OFS_CMD):  rdata = {{(REG_W-1){1'b0}}, enabled};
            RA_W'(OFS_STAT): rdata = {{(REG_W-1){1'b0}}, tc_flag};
            default:         rdata = '0;
        endcase
    end

    // R3
    step_chk: assert property (@(posedge clk) disable iff (rst)
        word_done && !last && !wr_any |=>
            (cur_addr == $past(cur_addr) + REG_W'(1)) && (cur_cnt == $past(cur_cnt) - REG_W'(1)));

    // R9
    tc_set_chk: assert property (@(posedge clk) disable iff (rst)
        word_done && last |=> tc_flag);

    // R10
    reload_chk: assert property (@(posedge clk) disable iff (rst)
        word_done && last && cfg.autoload && !wr_any |=>
            (cur_addr == base_addr) && (cur_cnt == base_cnt));

endmodule

// File: rtl/dmac_seq.sv
module dmac_seq
    import dmac_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       enabled,
    input  logic       cnt_zero,
    input  logic       last,
    input  xfer_kind_e kind,
    input  logic       dreq,
    input  logic       hold_ack,
    input  logic       ready,
    output seq_state_e state,
    output logic       word_done
);
    seq_state_e nxt;

    assign word_done = (state == ST_MOVE) && ready;

    always_comb begin
        nxt = state;
        case (state)
            ST_IDLE: if (enabled && !cnt_zero && dreq && !hold_ack) nxt = ST_ASK;
            ST_ASK:  if (hold_ack) nxt = ST_MOVE;
            ST_MOVE: if (ready) nxt = keep_bus(kind, dreq, last) ? ST_MOVE : ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end

    // R8
    demand_release_chk: assert property (@(posedge clk) disable iff (rst)
        word_done && kind == XM_DEMAND && !dreq |=> state == ST_IDLE);

    // R7
    block_hold_chk: assert property (@(posedge clk) disable iff (rst)
        word_done && kind == XM_BLOCK && !last |=> state == ST_MOVE);

endmodule

// File: rtl/dmac_channel.sv
module dmac_channel
    import dmac_pkg::*;
#(
    parameter int REG_W = 16,
    parameter int RA_W  = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cs,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [RA_W-1:0]  reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             dreq,
    output logic             dack,
    output logic             hold_req,
    input  logic             hold_ack,
    input  logic             ready,
    output logic [REG_W-1:0] mem_addr,
    output logic             mem_rd,
    output logic             mem_wr,
    output logic             irq
);
    logic [REG_W-1:0] cur_addr;
    logic [REG_W-1:0] cur_cnt;
    mode_cfg_t        cfg;
    logic             enabled, last, cnt_zero, tc_flag, word_done;
    seq_state_e       state;
    logic             moving;

    dmac_regs #(.REG_W(REG_W), .RA_W(RA_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .cs       (cs),
        .wr       (reg_wr),
        .rd       (reg_rd),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .word_done(word_done),
        .rdata    (reg_rdata),
        .cur_addr (cur_addr),
        .cur_cnt  (cur_cnt),
        .cfg      (cfg),
        .enabled  (enabled),
        .last     (last),
        .cnt_zero (cnt_zero),
        .tc_flag  (tc_flag)
    );

    dmac_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .enabled  (enabled),
        .cnt_zero (cnt_zero),
        .last     (last),
        .kind     (cfg.kind),
        .dreq     (dreq),
        .hold_ack (hold_ack),
        .ready    (ready),
        .state    (state),
        .word_done(word_done)
    );

    assign moving   = (state == ST_MOVE);
    assign hold_req = (state != ST_IDLE);
    assign dack     = moving;
    assign mem_rd   = moving && !cfg.to_mem;
    assign mem_wr   = moving &&  cfg.to_mem;
    assign mem_addr = moving ? cur_addr : '0;
    assign irq      = tc_flag;

    // R5
    one_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({mem_rd, mem_wr}));

    // R2
    bus_owned_chk: assert property (@(posedge clk) disable iff (rst)
        (dack || mem_rd || mem_wr) |-> hold_ack);

    // R2
    ask_cond_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(hold_req) |-> $past(enabled && dreq && !hold_ack && !cnt_zero));

    // R4
    stretch_chk: assert property (@(posedge clk) disable iff (rst)
        dack && !ready |=> dack && $stable(mem_addr) && $stable(mem_wr) && $stable(mem_rd));

    // R6
    single_drop_chk: assert property (@(posedge clk) disable iff (rst)
        word_done && cfg.kind == XM_SINGLE |=> !hold_req);

endmodule

// File: tb/tb_dmac_channel.sv
module tb_dmac_channel;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cs = 1'b0, reg_wr = 1'b0, reg_rd = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        dreq = 1'b0, dack, hold_req, hold_ack = 1'b0, ready = 1'b1;
    logic [15:0] mem_addr;
    logic        mem_rd, mem_wr, irq;

    always #5 clk = ~clk;

    dmac_channel dut (
        .clk(clk), .rst(rst), .cs(cs), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .dreq(dreq), .dack(dack), .hold_req(hold_req), .hold_ack(hold_ack),
        .ready(ready), .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .irq(irq)
    );

    int total = 0;
    int bad   = 0;

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // bus arbiter: grant follows request half a cycle later
    always @(negedge clk) hold_ack <= hold_req;

    // memory and peripheral model
    logic [15:0] mem [0:255];
    logic [15:0] io_word = 16'hA000;
    logic [15:0] sink [$];
    int          nwr = 0;
    initial for (int i = 0; i < 256; i++) mem[i] = 16'h1000 + 16'(i);

    always @(posedge clk) begin
        if (mem_wr && ready) begin
            mem[mem_addr[7:0]] <= io_word;
            io_word <= io_word + 16'd1;
            nwr <= nwr + 1;
        end
        if (mem_rd && ready) sink.push_back(mem[mem_addr[7:0]]);
    end

    // hold-request rising edges
    logic prev_hr = 1'b0;
    int   rises = 0;
    always @(posedge clk) begin
        prev_hr <= hold_req;
        if (hold_req && !prev_hr) rises <= rises + 1;
    end

    // behavioural reference model
    int          ms = 0;
    logic [15:0] ma = 0, mc = 0, mba = 0, mbc = 0;
    logic [1:0]  mkind = 0;
    logic        mdir = 0, mauto = 0, men = 0, mtc = 0;

    always @(posedge clk) begin
        if (rst) begin
            ms <= 0; ma <= 0; mc <= 0; mba <= 0; mbc <= 0;
            mkind <= 0; mdir <= 0; mauto <= 0; men <= 0; mtc <= 0;
        end else begin
            if (cs && reg_wr) begin
                case (reg_addr)
                    4'd0: begin mba <= reg_wdata; ma <= reg_wdata; end
                    4'd1: begin mbc <= reg_wdata; mc <= reg_wdata; end
                    4'd2: begin mkind <= reg_wdata[1:0]; mdir <= reg_wdata[2]; mauto <= reg_wdata[3]; end
                    4'd3: men <= reg_wdata[0];
                    default: ;
                endcase
            end
            if (cs && reg_rd && reg_addr == 4'd4) mtc <= 1'b0;
            if (ms == 0) begin
                if (men && mc != 0 && dreq && !hold_ack) ms <= 1;
            end else if (ms == 1) begin
                if (hold_ack) ms <= 2;
            end else if (ready) begin
                if (mc == 1) begin
                    mtc <= 1'b1;
                    ms  <= 0;
                    if (mauto) begin ma <= mba; mc <= mbc; end
                    else begin ma <= ma + 16'd1; mc <= 16'd0; end
                end else begin
                    ma <= ma + 16'd1;
                    mc <= mc - 16'd1;
                    ms <= (mkind == 2'd1 || (mkind == 2'd2 && dreq)) ? 2 : 0;
                end
            end
        end
    end

    function automatic logic [15:0] model_rd(input logic [3:0] a);
        case (a)
            4'd0: return ma;
            4'd1: return mc;
            4'd2: return {12'd0, mauto, mdir, mkind};
            4'd3: return {15'd0, men};
            4'd4: return {15'd0, mtc};
            default: return 16'd0;
        endcase
    endfunction

    // per-cycle comparison, away from the edges
    always @(posedge clk) begin
        #4;
        if (!rst) begin
            check(hold_req == (ms != 0), "R2 hold_req", hold_req, ms != 0);
            check(dack == (ms == 2), "R2 dack", dack, ms == 2);
            check(mem_wr == (ms == 2 && mdir), "R5 mem_wr", mem_wr, ms == 2 && mdir);
            check(mem_rd == (ms == 2 && !mdir), "R5 mem_rd", mem_rd, ms == 2 && !mdir);
            check(mem_addr == ((ms == 2) ? ma : 16'd0), "R3 mem_addr", mem_addr, (ms == 2) ? ma : 16'd0);
            check(irq == mtc, "R9 irq", irq, mtc);
            if (cs && reg_rd)
                check(reg_rdata == model_rd(reg_addr), "R1 rdata", reg_rdata, model_rd(reg_addr));
        end
    end

    task automatic wr_reg(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        cs = 1'b1; reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        cs = 1'b0; reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [3:0] a, output logic [15:0] d);
        @(negedge clk);
        cs = 1'b1; reg_rd = 1'b1; reg_addr = a;
        #2 d = reg_rdata;
        @(negedge clk);
        cs = 1'b0; reg_rd = 1'b0;
    endtask

    task automatic wait_irq(input string tag);
        int n = 0;
        while (!irq && n < 400) begin @(negedge clk); n++; end
        check(irq, tag, irq, 1);
    endtask

    task automatic wait_dack();
        int n = 0;
        while (!dack && n < 100) begin @(negedge clk); n++; end
    endtask

    // watchdog
    bit done = 1'b0;
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        int          r0, w0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // reset state R1
        check(!hold_req, "R1 reset hold_req", hold_req, 0);
        for (int a = 0; a < 5; a++) begin
            rd_reg(4'(a), v);
            check(v == 16'd0, "R1 reset register", v, 0);
        end

        // single mode, peripheral to memory R6
        wr_reg(4'd0, 16'h0010);
        wr_reg(4'd1, 16'd3);
        wr_reg(4'd2, 16'h0004);
        rd_reg(4'd2, v);
        check(v == 16'h0004, "R1 mode readback", v, 16'h0004);
        r0 = rises;
        wr_reg(4'd3, 16'h0001);
        @(negedge clk); dreq = 1'b1;
        wait_irq("R9 single irq");
        @(negedge clk); dreq = 1'b0;
        check(rises - r0 == 3, "R6 grants per word", rises - r0, 3);
        for (int i = 0; i < 3; i++)
            check(mem[16 + i] == 16'hA000 + 16'(i), "R5 memory write", mem[16 + i], 16'hA000 + 16'(i));
        rd_reg(4'd0, v);
        check(v == 16'h0013, "R3 final address", v, 16'h0013);
        rd_reg(4'd1, v);
        check(v == 16'd0, "R3 final count", v, 0);
        rd_reg(4'd4, v);
        check(v == 16'd1, "R9 status set", v, 1);
        rd_reg(4'd4, v);
        check(v == 16'd0, "R9 status cleared", v, 0);
        check(!irq, "R9 irq cleared", irq, 0);

        // block mode, memory to peripheral, with ready stalls R7 R4
        wr_reg(4'd0, 16'h0010);
        wr_reg(4'd1, 16'd3);
        wr_reg(4'd2, 16'h0001);
        r0 = rises;
        @(negedge clk); dreq = 1'b1;
        wait_dack();
        dreq = 1'b0; ready = 1'b0;
        repeat (3) @(negedge clk);
        ready = 1'b1;
        wait_irq("R7 block irq");
        check(rises - r0 == 1, "R7 single grant", rises - r0, 1);
        check(sink.size() == 3, "R4 words read", sink.size(), 3);
        for (int i = 0; i < 3 && i < sink.size(); i++)
            check(sink[i] == 16'hA000 + 16'(i), "R5 memory read", sink[i], 16'hA000 + 16'(i));
        rd_reg(4'd4, v);

        // demand mode with a pause R8
        wr_reg(4'd0, 16'h0040);
        wr_reg(4'd1, 16'd5);
        wr_reg(4'd2, 16'h0006);
        w0 = nwr;
        @(negedge clk); dreq = 1'b1;
        while (nwr - w0 < 2) @(negedge clk);
        dreq = 1'b0;
        repeat (6) @(negedge clk);
        check(!hold_req, "R8 bus released", hold_req, 0);
        rd_reg(4'd1, v);
        check(v == 16'(5 - (nwr - w0)) && nwr - w0 < 5, "R8 count kept", v, 5 - (nwr - w0));
        rd_reg(4'd0, v);
        check(v == 16'(16'h40 + nwr - w0), "R8 address kept", v, 16'h40 + nwr - w0);
        @(negedge clk); dreq = 1'b1;
        wait_irq("R8 demand irq");
        @(negedge clk); dreq = 1'b0;
        for (int i = 0; i < 5; i++)
            check(mem[64 + i] == 16'hA003 + 16'(i), "R8 demand data", mem[64 + i], 16'hA003 + 16'(i));
        rd_reg(4'd4, v);

        // auto-reload R10
        wr_reg(4'd0, 16'h0080);
        wr_reg(4'd1, 16'd2);
        wr_reg(4'd2, 16'h000D);
        @(negedge clk); dreq = 1'b1;
        wait_dack();
        dreq = 1'b0;
        wait_irq("R10 first run irq");
        repeat (3) @(negedge clk);
        rd_reg(4'd0, v);
        check(v == 16'h0080, "R10 address reloaded", v, 16'h0080);
        rd_reg(4'd1, v);
        check(v == 16'd2, "R10 count reloaded", v, 2);
        rd_reg(4'd4, v);
        @(negedge clk); dreq = 1'b1;
        wait_dack();
        dreq = 1'b0;
        wait_irq("R10 second run irq");
        check(mem[128] == 16'hA00A && mem[129] == 16'hA00B, "R10 rerun data",
              {mem[128], mem[129]}, {16'hA00A, 16'hA00B});
        rd_reg(4'd4, v);
        repeat (3) @(negedge clk);

        // disabled and zero-count channel R11
        wr_reg(4'd2, 16'h0004);
        wr_reg(4'd1, 16'd4);
        wr_reg(4'd3, 16'h0000);
        r0 = rises;
        @(negedge clk); dreq = 1'b1;
        repeat (12) @(negedge clk);
        check(rises == r0, "R11 disabled no request", rises - r0, 0);
        dreq = 1'b0;
        wr_reg(4'd1, 16'd0);
        wr_reg(4'd3, 16'h0001);
        @(negedge clk); dreq = 1'b1;
        repeat (12) @(negedge clk);
        check(rises == r0, "R11 zero count no request", rises - r0, 0);
        dreq = 1'b0;
        repeat (4) @(negedge clk);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule